// File: doc/BRIEF.md
# Reversible-Cell Two's-Complement Adder-Subtractor

This block adds or subtracts two N-bit two's-complement operands. It is purely combinational, and its width defaults to 4. Each bit position uses one four-input, four-output reversible gate as a full adder. One data input of that gate is tied to a constant zero.

In subtract mode, the B operand is inverted by a row of two-input reversible copy-and-XOR gates whose control input is the mode bit. The mode bit also seeds the carry into the least significant cell, so the ripple chain computes A plus the one's complement of B plus one.

The outputs are the wrapped N-bit result and a single flag. The flag is the carry-out when adding and the borrow when subtracting. Every output of every gate that the arithmetic does not consume is brought out on a side bus. Those outputs can be used to observe the internal carry chain.

The gate primitive is a module of its own. It can be checked over all sixteen input patterns.

Top module: `rev_addsub`

## Requirements
- R1: The gate primitive, with its inputs read as a 4-bit index {a,b,c,d} where a is the MSB, drives outP high exactly for indices 8 to 15 (outP = a) and drives outQ high exactly for indices 2, 3, 6, 7, 8, 9, 12 and 13 (outQ = a XOR c).
- R2: The gate primitive drives outR high exactly for indices 1, 2, 4, 7, 8, 9, 14 and 15, and drives outS high exactly for indices 1, 5, 6, 7, 9, 10, 12 and 14.
- R3: The gate primitive maps the sixteen input patterns to sixteen distinct output patterns {outP,outQ,outR,outS}.
- R4: With modeSub = 0, `result` equals (opA + opB) mod 2^N and `carryFlag` equals bit N of the unwrapped sum.
- R5: With modeSub = 1, `result` equals (opA - opB) mod 2^N.
- R6: With modeSub = 1, `carryFlag` is the borrow. It is 1 exactly when opA < opB as unsigned numbers, which is the inverse of the final ripple carry.
- R7: For each stage i, `garbage[2i]` equals opA[i], and `garbage[2i+1]` equals opA[i] XOR the carry into stage i. The carry into stage 0 is modeSub.
- R8: For each stage i, `garbage[2N+i]` carries a copy of modeSub (the pass-through output of the operand-inverting gate).
- R9: With both operands zero and modeSub = 0, `result`, `carryFlag` and the whole garbage bus are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | N | First operand (minuend when subtracting) |
| opB | input | N | Second operand (subtrahend when subtracting) |
| modeSub | input | 1 | 0 = add, 1 = subtract |
| result | output | N | Sum or difference, wrapped modulo 2^N |
| carryFlag | output | 1 | Carry-out when adding, borrow when subtracting |
| garbage | output | 3N | Unused gate outputs: per-stage pairs in bits 2N-1:0, mode copies in bits 3N-1:2N |

## Verification
The block holds no state, so a wrong internal signal shows at the ports in the same evaluation in which its inputs settle. A broken gate equation or a miswired carry link corrupts `result` or `carryFlag` for some operand pair. Exhaustive operand coverage at the default width therefore exposes it.

A carry that is wrong but happens to be masked in the final sum still shows on the odd garbage bits. Those bits expose the carry into every stage. A wrong mode decode shows at once on the upper garbage bits and on the seed visible in `garbage[1]`.

// File: rtl/rev_addsub_pkg.sv
package rev_addsub_pkg;
  // Strobes from the mode decode into the datapath
  typedef struct packed {
    logic invertB;    // control input of the operand-inverting gates
    logic seedCarry;  // carry into the least significant cell
    logic flipFinal;  // turn the final carry into a borrow
  } ctrlStrobes_t;
endpackage

// File: rtl/rev_quad_gate.sv
// Four-input, four-output reversible gate primitive.
module rev_quad_gate (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  input  logic inD,
  output logic outP,
  output logic outQ,
  output logic outR,
  output logic outS
);
  logic nandTerm;
  logic mixTerm;

  always_comb begin
    nandTerm = (~inA & ~inD) ^ ~inB;
    mixTerm  = (inA & inB) ^ inD;
    outP     = inA;
    outQ     = inA ^ inC;
    outR     = nandTerm ^ inC;
    outS     = (nandTerm & inC) ^ mixTerm;
  end
endmodule

// File: rtl/rev_feynman.sv
// Two-input copy-and-XOR reversible gate.
module rev_feynman (
  input  logic ctlIn,
  input  logic dataIn,
  output logic ctlCopy,
  output logic dataXor
);
  assign ctlCopy = ctlIn;
  assign dataXor = ctlIn ^ dataIn;
endmodule

// File: rtl/rev_addsub_ctrl.sv
module rev_addsub_ctrl
  import rev_addsub_pkg::*;
(
  input  logic         modeSub,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.invertB   = modeSub;
    strobes.seedCarry = modeSub;
    strobes.flipFinal = modeSub;
  end
endmodule

// File: rtl/rev_addsub_dp.sv
module rev_addsub_dp
  import rev_addsub_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  input  ctrlStrobes_t   strobes,
  output logic [N-1:0]   result,
  output logic           carryFlag,
  output logic [3*N-1:0] garbage
);
  localparam int CELL_GARB = 2 * N;

  logic [N:0]   carryChain;
  logic [N-1:0] bEff;
  logic [N-1:0] modeCopy;
  logic [N-1:0] cellP;
  logic [N-1:0] cellQ;

  assign carryChain[0] = strobes.seedCarry;

  for (genvar i = 0; i < N; i++) begin : g_stage
    rev_feynman u_inv (
      .ctlIn  (strobes.invertB),
      .dataIn (opB[i]),
      .ctlCopy(modeCopy[i]),
      .dataXor(bEff[i])
    );

    // Full-adder use: D tied to 0, R is the sum, S is the carry-out
    rev_quad_gate u_cell (
      .inA (opA[i]),
      .inB (bEff[i]),
      .inC (carryChain[i]),
      .inD (1'b0),
      .outP(cellP[i]),
      .outQ(cellQ[i]),
      .outR(result[i]),
      .outS(carryChain[i+1])
    );

    assign garbage[2*i]         = cellP[i];
    assign garbage[2*i+1]       = cellQ[i];
    assign garbage[CELL_GARB+i] = modeCopy[i];
  end

  assign carryFlag = carryChain[N] ^ strobes.flipFinal;
endmodule

// File: rtl/rev_addsub.sv
module rev_addsub
  import rev_addsub_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  input  logic           modeSub,
  output logic [N-1:0]   result,
  output logic           carryFlag,
  output logic [3*N-1:0] garbage
);
  ctrlStrobes_t strobes;

  rev_addsub_ctrl u_ctrl (
    .modeSub(modeSub),
    .strobes(strobes)
  );

  rev_addsub_dp #(.N(N)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryFlag(carryFlag),
    .garbage  (garbage)
  );
endmodule

// File: rtl/rev_addsub_chk.sv
module rev_addsub_chk #(
  parameter int N = 4
) (
  input logic [N-1:0]   opA,
  input logic [N-1:0]   opB,
  input logic           modeSub,
  input logic [N-1:0]   result,
  input logic           carryFlag,
  input logic [3*N-1:0] garbage
);
  logic [N:0]   wideSum;
  logic [N-1:0] diff;

  always_comb begin
    wideSum = {1'b0, opA} + {1'b0, opB};
    diff    = opA - opB;
    if (!modeSub) begin
      AST_ADD_SUM: assert ({carryFlag, result} == wideSum);                 // R4
    end else begin
      AST_SUB_DIFF: assert (result == diff);                               // R5
      AST_SUB_BORROW: assert (carryFlag == (opA < opB));                   // R6
    end
    AST_SEED_CARRY: assert (garbage[1] == (opA[0] ^ modeSub));             // R7
    AST_MODE_COPIES: assert (garbage[3*N-1:2*N] == {N{modeSub}});          // R8
  end
endmodule

bind rev_addsub rev_addsub_chk #(.N(N)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .modeSub  (modeSub),
  .result   (result),
  .carryFlag(carryFlag),
  .garbage  (garbage)
);

// File: tb/rev_addsub_tb.sv
module rev_addsub_tb;
  localparam int W = 4;

  typedef struct {
    logic [W-1:0]   expRes;
    logic           expFlag;
    logic [3*W-1:0] expGarb;
    logic           isSub;
    logic           isZero;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]   opA = '0;
  logic [W-1:0]   opB = '0;
  logic           modeSub = 1'b0;
  logic [W-1:0]   result;
  logic           carryFlag;
  logic [3*W-1:0] garbage;

  rev_addsub #(.N(W)) u_dut (
    .opA(opA), .opB(opB), .modeSub(modeSub),
    .result(result), .carryFlag(carryFlag), .garbage(garbage)
  );

  logic gA = 0, gB = 0, gC = 0, gD = 0;
  logic gP, gQ, gR, gS;
  rev_quad_gate u_gate (
    .inA(gA), .inB(gB), .inC(gC), .inD(gD),
    .outP(gP), .outQ(gQ), .outR(gR), .outS(gS)
  );

  int compared = 0;
  int mismatched = 0;
  item_t sbQ[$];
  bit driveDone = 0;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    item_t it;
    logic [W-1:0] bEff;
    logic [W:0]   full;
    logic [W-1:0] cin;
    @(posedge clk);
    opA = a; opB = b; modeSub = m;
    bEff = m ? ~b : b;
    full = {1'b0, a} + {1'b0, bEff} + {{W{1'b0}}, m};
    cin  = full[W-1:0] ^ a ^ bEff;
    it.expRes  = m ? (a - b) : (a + b);
    it.expFlag = m ? (a < b) : full[W];
    for (int i = 0; i < W; i++) begin
      it.expGarb[2*i]   = a[i];
      it.expGarb[2*i+1] = a[i] ^ cin[i];
      it.expGarb[2*W+i] = m;
    end
    it.isSub  = m;
    it.isZero = (a == 0) && (b == 0) && !m;
    sbQ.push_back(it);
  endtask

  // Monitor: compares half a cycle after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        if (it.isZero) begin
          check("R9 zero result", int'(result), 0);
          check("R9 zero flag", int'(carryFlag), 0);
          check("R9 zero garbage", int'(garbage), 0);
        end
        if (it.isSub) begin
          check("R5 difference", int'(result), int'(it.expRes));
          check("R6 borrow", int'(carryFlag), int'(it.expFlag));
        end else begin
          check("R4 sum", int'(result), int'(it.expRes));
          check("R4 carry", int'(carryFlag), int'(it.expFlag));
        end
        check("R7 cell garbage", int'(garbage[2*W-1:0]), int'(it.expGarb[2*W-1:0]));
        check("R8 mode copies", int'(garbage[3*W-1:2*W]), int'(it.expGarb[3*W-1:2*W]));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] seen;
    logic [15:0] maskP, maskQ, maskR, maskS;
    maskP = 16'hFF00; maskQ = 16'h33CC; maskR = 16'hC396; maskS = 16'h56E2;
    seen = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Exhaustive gate primitive check
    for (int idx = 0; idx < 16; idx++) begin
      {gA, gB, gC, gD} = 4'(idx);
      #1;
      check("R1 gate P", int'(gP), int'(maskP[idx]));
      check("R1 gate Q", int'(gQ), int'(maskQ[idx]));
      check("R2 gate R", int'(gR), int'(maskR[idx]));
      check("R2 gate S", int'(gS), int'(maskS[idx]));
      check("R3 distinct output", int'(seen[{gP, gQ, gR, gS}]), 0);
      seen[{gP, gQ, gR, gS}] = 1'b1;
    end
    check("R3 all outputs hit", int'(seen), 16'hFFFF);

    // Zero inputs (rest state) first, then every operand pair in both modes
    drive('0, '0, 1'b0);
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          drive(W'(a), W'(b), m[0]);
    driveDone = 1;
    @(posedge clk);
    @(posedge clk);
    check("R4 queue drained", sbQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule